// File: doc/BRIEF.md
# Bounded Ticket Allocator and Recency Selector

This block does the tag bookkeeping for one requester of a shared register that many requesters write and read with no waiting on each other. Each requester owns a small private pool of ticket names. For a write, the block receives every one of its own ticket names that it has observed in the fields of the other requesters, treats all of them as unusable, and hands back the lowest-numbered name left over. It also builds the view that the write will publish. That view has the fresh ticket in the requester's own slot, and in every other slot k the entry k of the view polled from requester k.

For a read, the block receives all polled views, one per requester, each holding one ticket name per requester. It reports which requester wrote most recently. A view m counts as most recent when its own entry m appears as entry m in no other view. If more than one view qualifies, the highest index wins. If none qualifies, an error flag is raised and the requester's own index is returned. The pool holds 2n²−n+1 names, one more than the largest number that can be unusable at once, so a write always finds a name. Both functions take one clock cycle from request to a registered result.

Top module: `bounded_tix_alloc`

## Requirements
- R1: After reset, wr_vld_o and rd_vld_o are low, and new_tix_o, new_view_o, sel_idx_o and sel_err_o are zero.
- R2: A wr_req_i sampled high at a rising edge makes wr_vld_o high for exactly the following cycle. wr_vld_o is low in any cycle that does not follow a write request.
- R3: The ticket returned for a write differs from every observation slot k whose obs_vld_i bit k is set. Slot k is obs_tix_i bits [k*TW +: TW].
- R4: The returned ticket is the lowest-numbered name in the pool (0 .. 2n²−n) that is not observed.
- R5: An observation slot whose valid bit is clear has no effect on the chosen ticket.
- R6: When all 2n²−n slots are valid and carry distinct names, a name is still returned: the one name left unobserved.
- R7: The new view holds the chosen ticket at entry OWN_IDX and, for each other k, entry k of polled view k. View j entry k is views_i bits [(j*N_REQ+k)*TW +: TW]. New view entry k is new_view_o bits [k*TW +: TW].
- R8: A rd_req_i sampled high makes rd_vld_o high for the next cycle. sel_idx_o is then the largest m such that entry m of view m equals entry m of no other view, and sel_err_o is low.
- R9: If no view qualifies, sel_err_o is high and sel_idx_o equals OWN_IDX.
- R10: A write request and a read request in the same cycle both complete in the next cycle, each with the result it would have alone.
- R11: With no request, wr_vld_o and rd_vld_o are low and the ticket, view and index outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Start of a write: allocate a ticket and compose a view |
| obs_tix_i | input | NOBS*TW | Own ticket names observed in polled fields, one per slot |
| obs_vld_i | input | NOBS | Valid bit per observation slot |
| rd_req_i | input | 1 | Start of a read: run the recency test |
| views_i | input | N_REQ*N_REQ*TW | Polled views, view j entry k at (j*N_REQ+k)*TW |
| wr_vld_o | output | 1 | Write result valid, one cycle |
| new_tix_o | output | TW | Chosen ticket |
| new_view_o | output | N_REQ*TW | Composed view for publication |
| rd_vld_o | output | 1 | Read result valid, one cycle |
| sel_idx_o | output | IW | Index of the most recent writer |
| sel_err_o | output | 1 | No view passed the recency test |

## Verification
Allocation and the recency test share the polled views and have separate registered outputs, so both can be requested in the same cycle. The bench raises both requests on one edge, using views where two candidates qualify and observations that block ticket zero. It then checks the ticket, the composed view, the selected index and the error flag against the values each function gives when requested alone.

// File: rtl/tix_pkg.sv
package tix_pkg;
   // Number of names per requester pool: one more than the worst-case
   // count of own tickets that can be unusable at the same time.
   function automatic int pool_names(input int n);
      return 2 * n * n - n + 1;
   endfunction

   function automatic int max_obs(input int n);
      return 2 * n * n - n;
   endfunction
endpackage

// File: rtl/tix_discredit_map.sv
module tix_discredit_map #(
   parameter int POOL = 16,
   parameter int NOBS = 15,
   parameter int TW   = 4
) (
   input  logic [NOBS*TW-1:0] obs_tix_i,
   input  logic [NOBS-1:0]    obs_vld_i,
   output logic [POOL-1:0]    used_o
);
   for (genvar p = 0; p < POOL; p++) begin : g_name
      logic [NOBS-1:0] hit;
      for (genvar k = 0; k < NOBS; k++) begin : g_slot
         assign hit[k] = obs_vld_i[k] && (obs_tix_i[k*TW +: TW] == TW'(p));
      end
      assign used_o[p] = |hit;
   end
endmodule

// File: rtl/tix_free_pick.sv
module tix_free_pick #(
   parameter int POOL = 16,
   parameter int TW   = 4
) (
   input  logic [POOL-1:0] used_i,
   output logic [TW-1:0]   pick_o
);
   always_comb begin
      pick_o = '0;
      for (int p = POOL - 1; p >= 0; p--) begin
         if (!used_i[p]) pick_o = TW'(p);
      end
   end
endmodule

// File: rtl/view_sink_sel.sv
module view_sink_sel #(
   parameter int N_REQ   = 3,
   parameter int OWN_IDX = 0,
   parameter int TW      = 4,
   parameter int IW      = 2
) (
   input  logic [N_REQ*N_REQ*TW-1:0] views_i,
   output logic [IW-1:0]             idx_o,
   output logic                      err_o
);
   logic [N_REQ-1:0] qual;

   for (genvar m = 0; m < N_REQ; m++) begin : g_cand
      logic [N_REQ-1:0] differs;
      for (genvar j = 0; j < N_REQ; j++) begin : g_other
         if (j == m) begin : g_self
            assign differs[j] = 1'b1;
         end else begin : g_cmp
            assign differs[j] = views_i[(j*N_REQ+m)*TW +: TW]
                             != views_i[(m*N_REQ+m)*TW +: TW];
         end
      end
      assign qual[m] = &differs;
   end

   always_comb begin
      idx_o = IW'(OWN_IDX);
      err_o = 1'b1;
      for (int m = 0; m < N_REQ; m++) begin
         if (qual[m]) begin
            idx_o = IW'(m);
            err_o = 1'b0;
         end
      end
   end
endmodule

// File: rtl/bounded_tix_alloc.sv
module bounded_tix_alloc #(
   parameter int N_REQ   = 3,
   parameter int OWN_IDX = 1,
   parameter int POOL    = tix_pkg::pool_names(N_REQ),
   parameter int NOBS    = tix_pkg::max_obs(N_REQ),
   parameter int TW      = $clog2(POOL),
   parameter int IW      = $clog2(N_REQ)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_req_i,
   input  logic [NOBS*TW-1:0]        obs_tix_i,
   input  logic [NOBS-1:0]           obs_vld_i,
   input  logic                      rd_req_i,
   input  logic [N_REQ*N_REQ*TW-1:0] views_i,
   output logic                      wr_vld_o,
   output logic [TW-1:0]             new_tix_o,
   output logic [N_REQ*TW-1:0]       new_view_o,
   output logic                      rd_vld_o,
   output logic [IW-1:0]             sel_idx_o,
   output logic                      sel_err_o
);
   localparam int VIEW_W = N_REQ * TW;

   if (N_REQ < 2) begin : g_bad_n
      $error("N_REQ must be at least 2");
   end
   if (OWN_IDX >= N_REQ) begin : g_bad_own
      $error("OWN_IDX must be below N_REQ");
   end
   if (NOBS >= POOL) begin : g_bad_pool
      $error("pool must exceed the observation count");
   end
   if ((1 << TW) < POOL) begin : g_bad_tw
      $error("TW too narrow for the pool");
   end

   logic [POOL-1:0]   used;
   logic [TW-1:0]     pick;
   logic [VIEW_W-1:0] comp_view;
   logic [IW-1:0]     sink_idx;
   logic              sink_err;

   tix_discredit_map #(.POOL(POOL), .NOBS(NOBS), .TW(TW)) i_map (
      .obs_tix_i (obs_tix_i),
      .obs_vld_i (obs_vld_i),
      .used_o    (used)
   );

   tix_free_pick #(.POOL(POOL), .TW(TW)) i_pick (
      .used_i (used),
      .pick_o (pick)
   );

   view_sink_sel #(.N_REQ(N_REQ), .OWN_IDX(OWN_IDX), .TW(TW), .IW(IW)) i_sink (
      .views_i (views_i),
      .idx_o   (sink_idx),
      .err_o   (sink_err)
   );

   for (genvar k = 0; k < N_REQ; k++) begin : g_compose
      if (k == OWN_IDX) begin : g_own
         assign comp_view[k*TW +: TW] = pick;
      end else begin : g_copy
         assign comp_view[k*TW +: TW] = views_i[(k*N_REQ+k)*TW +: TW];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_vld_o   <= 1'b0;
         new_tix_o  <= '0;
         new_view_o <= '0;
      end else begin
         wr_vld_o <= wr_req_i;
         if (wr_req_i) begin
            new_tix_o  <= pick;
            new_view_o <= comp_view;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_vld_o  <= 1'b0;
         sel_idx_o <= '0;
         sel_err_o <= 1'b0;
      end else begin
         rd_vld_o <= rd_req_i;
         if (rd_req_i) begin
            sel_idx_o <= sink_idx;
            sel_err_o <= sink_err;
         end
      end
   end
endmodule

// File: rtl/tix_alloc_chk.sv
module tix_alloc_chk #(
   parameter int N_REQ   = 3,
   parameter int OWN_IDX = 1,
   parameter int POOL    = 16,
   parameter int NOBS    = 15,
   parameter int TW      = 4,
   parameter int IW      = 2
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               wr_req_i,
   input logic [NOBS*TW-1:0] obs_tix_i,
   input logic [NOBS-1:0]    obs_vld_i,
   input logic               rd_req_i,
   input logic               wr_vld_o,
   input logic [TW-1:0]      new_tix_o,
   input logic               rd_vld_o,
   input logic [IW-1:0]      sel_idx_o,
   input logic               sel_err_o
);
   logic [(1<<TW)-1:0] seen_d, seen_q;

   always_comb begin
      seen_d = '0;
      for (int k = 0; k < NOBS; k++) begin
         if (obs_vld_i[k]) seen_d[obs_tix_i[k*TW +: TW]] = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= '0;
      else         seen_q <= seen_d;
   end

   p_wr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_i |=> wr_vld_o);
   p_wr_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_req_i |=> !wr_vld_o);
   p_fresh_tix_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_o |-> !seen_q[new_tix_o]);
   p_in_pool_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_o |-> (32'(new_tix_o) < POOL));
   p_rd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_i |=> rd_vld_o);
   p_err_own_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_vld_o && sel_err_o) |-> (sel_idx_o == IW'(OWN_IDX)));
   p_hold_tix_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_req_i |=> $stable(new_tix_o));
   p_hold_idx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_req_i |=> ($stable(sel_idx_o) && !rd_vld_o));
endmodule

bind bounded_tix_alloc tix_alloc_chk #(
   .N_REQ(N_REQ), .OWN_IDX(OWN_IDX), .POOL(POOL), .NOBS(NOBS), .TW(TW), .IW(IW)
) i_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_req_i  (wr_req_i),
   .obs_tix_i (obs_tix_i),
   .obs_vld_i (obs_vld_i),
   .rd_req_i  (rd_req_i),
   .wr_vld_o  (wr_vld_o),
   .new_tix_o (new_tix_o),
   .rd_vld_o  (rd_vld_o),
   .sel_idx_o (sel_idx_o),
   .sel_err_o (sel_err_o)
);

// File: tb/test_bounded_tix_alloc.sv
module test_bounded_tix_alloc;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 3;
   localparam int OWN  = 1;
   localparam int POOL = 2 * N * N - N + 1;
   localparam int NOBS = 2 * N * N - N;
   localparam int TW   = $clog2(POOL);
   localparam int IW   = $clog2(N);

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  wr_req = 1'b0;
   logic                  rd_req = 1'b0;
   logic [NOBS*TW-1:0]    obs_tix = '0;
   logic [NOBS-1:0]       obs_vld = '0;
   logic [N*N*TW-1:0]     views = '0;
   logic                  wr_vld, rd_vld, sel_err;
   logic [TW-1:0]         new_tix;
   logic [N*TW-1:0]       new_view;
   logic [IW-1:0]         sel_idx;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bounded_tix_alloc #(.N_REQ(N), .OWN_IDX(OWN)) i_bounded_tix_alloc (
      .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .obs_tix_i(obs_tix),
      .obs_vld_i(obs_vld), .rd_req_i(rd_req), .views_i(views),
      .wr_vld_o(wr_vld), .new_tix_o(new_tix), .new_view_o(new_view),
      .rd_vld_o(rd_vld), .sel_idx_o(sel_idx), .sel_err_o(sel_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put_view(input int j, input int k, input int val);
      views[(j*N+k)*TW +: TW] = TW'(val);
   endtask

   task automatic put_obs(input int k, input int name, input bit v);
      obs_tix[k*TW +: TW] = TW'(name);
      obs_vld[k] = v;
   endtask

   function automatic int view_entry(input int k);
      return int'(new_view[k*TW +: TW]);
   endfunction

   // one request cycle, results sampled on the following falling edge
   task automatic pulse(input bit w, input bit r);
      @(negedge clk);
      wr_req = w;
      rd_req = r;
      @(negedge clk);
      wr_req = 1'b0;
      rd_req = 1'b0;
   endtask

   task automatic t_reset;
      check(!wr_vld && !rd_vld, "R1 valids low", int'(wr_vld) + int'(rd_vld), 0);
      check(new_tix == '0 && new_view == '0, "R1 write outputs zero", int'(new_tix), 0);
      check(sel_idx == '0 && !sel_err, "R1 read outputs zero", int'(sel_idx), 0);
   endtask

   task automatic t_lowest;
      obs_vld = '0;
      put_obs(0, 0, 1); put_obs(3, 2, 1); put_obs(7, 1, 1); put_obs(9, 5, 1);
      pulse(1, 0);
      check(wr_vld, "R2 write valid", int'(wr_vld), 1);
      check(new_tix == 4'd3, "R4 lowest free ticket", int'(new_tix), 3);
      check(new_tix != 4'd5, "R3 observed name avoided", int'(new_tix), 3);
      @(negedge clk);
      check(!wr_vld, "R2 single-cycle pulse", int'(wr_vld), 0);
   endtask

   task automatic t_masked;
      obs_vld = '0;
      put_obs(0, 0, 1); put_obs(1, 1, 1); put_obs(2, 2, 1); put_obs(4, 3, 0);
      pulse(1, 0);
      check(new_tix == 4'd3, "R5 masked slot ignored", int'(new_tix), 3);
   endtask

   task automatic t_full;
      for (int k = 0; k < NOBS; k++) put_obs(k, NOBS - 1 - k, 1);
      pulse(1, 0);
      check(new_tix == TW'(POOL - 1), "R6 full pool still yields name", int'(new_tix), POOL - 1);
      for (int k = 0; k < NOBS; k++) put_obs(k, k + 1, 1);
      pulse(1, 0);
      check(new_tix == 4'd0, "R6 only zero free", int'(new_tix), 0);
   endtask

   task automatic t_compose;
      views = '0;
      put_view(0, 0, 5); put_view(1, 0, 5);
      put_view(1, 1, 7); put_view(0, 1, 3); put_view(2, 1, 3);
      put_view(2, 2, 9); put_view(0, 2, 9);
      obs_vld = '0;
      put_obs(0, 0, 1); put_obs(1, 1, 1);
      pulse(1, 0);
      check(view_entry(0) == 5, "R7 entry 0 from view 0", view_entry(0), 5);
      check(view_entry(OWN) == 2, "R7 own entry is ticket", view_entry(OWN), 2);
      check(view_entry(2) == 9, "R7 entry 2 from view 2", view_entry(2), 9);
   endtask

   task automatic t_read;
      // single qualifier: view 1 (column 0 and 2 clash)
      pulse(0, 1);
      check(rd_vld, "R8 read valid", int'(rd_vld), 1);
      check(sel_idx == 2'd1 && !sel_err, "R8 sole sink", int'(sel_idx), 1);
      // views 1 and 2 qualify: largest wins
      put_view(0, 2, 4); put_view(1, 2, 4);
      pulse(0, 1);
      check(sel_idx == 2'd2 && !sel_err, "R8 largest sink", int'(sel_idx), 2);
      // only view 0 qualifies
      views = '0;
      put_view(0, 0, 6);
      pulse(0, 1);
      check(sel_idx == 2'd0 && !sel_err, "R8 sink at index 0", int'(sel_idx), 0);
      // nothing qualifies
      views = '0;
      pulse(0, 1);
      check(sel_err, "R9 error flag", int'(sel_err), 1);
      check(sel_idx == 2'(OWN), "R9 own index returned", int'(sel_idx), OWN);
   endtask

   task automatic t_both;
      views = '0;
      put_view(0, 0, 5); put_view(1, 0, 5);
      put_view(1, 1, 7); put_view(0, 1, 3); put_view(2, 1, 3);
      put_view(2, 2, 9); put_view(0, 2, 4); put_view(1, 2, 4);
      obs_vld = '0;
      put_obs(6, 0, 1);
      pulse(1, 1);
      check(wr_vld && rd_vld, "R10 both valid", int'(wr_vld) + int'(rd_vld), 2);
      check(new_tix == 4'd1, "R10 ticket", int'(new_tix), 1);
      check(view_entry(0) == 5 && view_entry(2) == 9, "R10 view", view_entry(2), 9);
      check(sel_idx == 2'd2 && !sel_err, "R10 index", int'(sel_idx), 2);
   endtask

   task automatic t_hold;
      obs_vld = '0;
      views = '0;
      @(negedge clk);
      @(negedge clk);
      check(!wr_vld && !rd_vld, "R11 idle valids low", int'(wr_vld) + int'(rd_vld), 0);
      check(new_tix == 4'd1, "R11 ticket held", int'(new_tix), 1);
      check(sel_idx == 2'd2 && !sel_err, "R11 index held", int'(sel_idx), 2);
      check(view_entry(2) == 9, "R11 view held", view_entry(2), 9);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_lowest();
      t_masked();
      t_full();
      t_compose();
      t_read();
      t_both();
      t_hold();
      finished = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end
endmodule